// File: doc/BRIEF.md
# Break-Detecting Start-Stop Serial Receiver

This block receives start-stop serial characters on a single line for one channel. A free-running clock drives it, along with a one-cycle enable pulse that arrives sixteen times per bit period from an external rate generator. The line first passes through a two-stage synchronizer. A falling edge marks a candidate start bit, and the receiver accepts it only if the line is still low at the middle of the bit. The receiver then samples every later bit at its middle. The character format comes from four static configuration inputs: 7 or 8 data bits, one or two stop bits, and no parity, even parity or odd parity.

Each completed character goes into a 16-entry first-word-fall-through queue. The entry holds the data byte and two per-character flags, one for a parity mismatch and one for a low stop bit. A consumer reads the head of the queue and pops it with a one-cycle read strobe. The queue also reports an empty flag and its fill level.

Two sticky flags report events that belong to no single stored character. The first is an overrun, meaning a character arrived while the queue was full and was dropped. The second is a line break, meaning a character with a low stop bit was followed by at least one further whole frame time of low line. Each flag has its own clear strobe. After a break, the receiver ignores the line until it has gone high again.

Top module: `rx_serial_brk`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_count`=0) and both sticky flags read 0.
- R2: Data bits are received least significant bit first. With `cfg_len7`=0, the stored byte equals the 8 transmitted bits. Characters leave the queue in arrival order.
- R3: With `cfg_len7`=1, 7 data bits are received and bit 7 of the stored byte is 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0 the total count of ones in data plus parity must be even, and with `cfg_par_odd`=1 it must be odd. A mismatch sets `rd_perr` for that entry. With `cfg_par_en`=0, `rd_perr` is always 0.
- R5: A first stop bit sampled low sets `rd_ferr` for that entry, and the character is still stored. A second stop bit (`cfg_stop2`=1) is never checked.
- R6: `brk_flag` sets when, after a low first stop bit, the line stays low for one more full frame time. The frame time is 16 enable pulses times (1 + data bits + parity bit + stop bits). If the line returns high earlier, `brk_flag` does not set.
- R7: After a break, no further character is stored while the line stays low. Reception resumes normally once the line has been high.
- R8: The queue holds 16 entries. `fifo_count` tracks pushes and pops. `rd_en` pops the head entry, and `rd_en` on an empty queue has no effect.
- R9: A character completed while 16 entries are held is discarded, and `ovr_flag` sets. The stored entries are unchanged.
- R10: `ovr_flag` and `brk_flag` stay set until a one-cycle pulse on `ovr_clr` or `brk_clr` respectively. If a set and a clear fall in the same cycle, the set wins.
- R11: A low pulse shorter than half a bit period is rejected as a false start and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| rxd_in | input | 1 | Serial receive line, idle high |
| os_tick | input | 1 | Enable pulse, 16 per bit period |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_par_en | input | 1 | 1: parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry data byte |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_count | output | 5 | Number of entries held |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clear pulse for `ovr_flag` |
| brk_flag | output | 1 | Sticky break flag |
| brk_clr | input | 1 | Clear pulse for `brk_flag` |

## Verification
A wrong bit index or tick phase corrupts the very next character. It shows at the head of the queue as a shifted byte or a false parity flag, as soon as that character's stop bit is sampled. A wrong frame-window count in the break checker shows one frame time later: either `brk_flag` rises during a short framing error, or it fails to rise during a held-low line. A receiver stuck after a break shows as a missing character after the line recovers. Queue pointer or count faults appear within one fill and drain of 16 entries, as mismatched order, a wrong level, or a wrong empty flag.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKCHK,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxb_deframe.sv
module rxb_deframe
  import rxb_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic      len7_i,
  input  logic      stop2_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      push_o,
  output rx_entry_t entry_o,
  output logic      brk_set_o
);
  localparam int TW     = $clog2(OS_RATE);
  localparam int MAXBIT = 12;
  localparam int BW     = $clog2(MAXBIT * OS_RATE + 1);
  localparam logic [TW-1:0] T_LAST = TW'(OS_RATE - 1);
  localparam logic [TW-1:0] T_HALF = TW'(OS_RATE / 2 - 1);

  rx_state_e         state_q, state_d;
  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic [2:0]        bidx_q, bidx_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              par_q, par_d;
  logic [3:0]        fbits;
  logic [BW-1:0]     win_last;
  logic [DATA_W-1:0] data_w;

  // frame length in bits and last tick of the break window
  always_comb begin
    fbits    = 4'd1 + (len7_i ? 4'd7 : 4'd8) + {3'd0, par_en_i} + (stop2_i ? 4'd2 : 4'd1);
    win_last = BW'(fbits) * BW'(OS_RATE) - BW'(1);
  end

  always_comb begin
    data_w        = len7_i ? {1'b0, shf_q[DATA_W-1:1]} : shf_q;
    entry_o.data  = data_w;
    entry_o.perr  = par_en_i & ((^data_w ^ par_q) != par_odd_i);
    entry_o.ferr  = ~rx_i;
  end

  always_comb begin
    state_d   = state_q;
    tcnt_d    = tcnt_q;
    bcnt_d    = bcnt_q;
    bidx_d    = bidx_q;
    shf_d     = shf_q;
    par_d     = par_q;
    push_o    = 1'b0;
    brk_set_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!rx_i) begin
          state_d = ST_START;
          tcnt_d  = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (tcnt_q == T_HALF) begin
            tcnt_d  = '0;
            bidx_d  = '0;
            state_d = rx_i ? ST_IDLE : ST_DATA;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d = '0;
            shf_d  = {rx_i, shf_q[DATA_W-1:1]};
            if (bidx_q == (len7_i ? 3'd6 : 3'd7))
              state_d = par_en_i ? ST_PAR : ST_STOP;
            else
              bidx_d = bidx_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (tick_i) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d  = '0;
            par_d   = rx_i;
            state_d = ST_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d = '0;
            push_o = 1'b1;
            bcnt_d = '0;
            state_d = rx_i ? ST_IDLE : ST_BRKCHK;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      ST_BRKCHK: begin
        if (rx_i) begin
          state_d = ST_IDLE;
        end else if (tick_i) begin
          if (bcnt_q == win_last) begin
            brk_set_o = 1'b1;
            state_d   = ST_WAITHI;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_WAITHI: begin
        if (rx_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      bidx_q  <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      bidx_q  <= bidx_d;
      shf_q   <= shf_d;
      par_q   <= par_d;
    end
  end

  // R3
  msb7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && len7_i) |-> !entry_o.data[DATA_W-1]);

  // R6
  brk_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set_o |-> !rx_i);
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import rxb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  rx_entry_t                  wdata_i,
  input  logic                       pop_i,
  output rx_entry_t                  rdata_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] P_LAST = AW'(DEPTH - 1);

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            do_wr, do_rd;

  always_comb begin
    full_o  = (cnt_q == CW'(DEPTH));
    empty_o = (cnt_q == '0);
    do_wr   = push_i & ~full_o;
    do_rd   = pop_i & ~empty_o;
    wp_d    = do_wr ? ((wp_q == P_LAST) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d    = do_rd ? ((rp_q == P_LAST) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_d   = cnt_q;
    if (do_wr && !do_rd)      cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop_i && !push_i) |=> (cnt_q == '0));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (cnt_q == $past(cnt_q) && wp_q == $past(wp_q)));
endmodule

// File: rtl/rx_serial_brk.sv
module rx_serial_brk
  import rxb_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rxd_in,
  input  logic                            os_tick,
  input  logic                            cfg_len7,
  input  logic                            cfg_stop2,
  input  logic                            cfg_par_en,
  input  logic                            cfg_par_odd,
  input  logic                            rd_en,
  output logic [7:0]                      rd_data,
  output logic                            rd_perr,
  output logic                            rd_ferr,
  output logic                            fifo_empty,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  output logic                            ovr_flag,
  input  logic                            ovr_clr,
  output logic                            brk_flag,
  input  logic                            brk_clr
);
  logic      rx_s;
  logic      push, brk_set, full, ovr_set;
  rx_entry_t wentry, rentry;
  logic      ovr_q, ovr_d, brk_q, brk_d;

  rxb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rxd_in), .q_o(rx_s)
  );

  rxb_deframe #(.OS_RATE(OS_RATE)) u_deframe (
    .clk(clk), .rst_n(rst_n), .tick_i(os_tick), .rx_i(rx_s),
    .len7_i(cfg_len7), .stop2_i(cfg_stop2), .par_en_i(cfg_par_en),
    .par_odd_i(cfg_par_odd), .push_o(push), .entry_o(wentry),
    .brk_set_o(brk_set)
  );

  rxb_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(wentry),
    .pop_i(rd_en), .rdata_o(rentry), .full_o(full),
    .empty_o(fifo_empty), .count_o(fifo_count)
  );

  always_comb begin
    ovr_set = push & full;
    ovr_d   = ovr_set ? 1'b1 : (ovr_clr ? 1'b0 : ovr_q);
    brk_d   = brk_set ? 1'b1 : (brk_clr ? 1'b0 : brk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
      brk_q <= brk_d;
    end
  end

  assign rd_data  = rentry.data;
  assign rd_perr  = rentry.perr;
  assign rd_ferr  = rentry.ferr;
  assign ovr_flag = ovr_q;
  assign brk_flag = brk_q;

  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !ovr_set) |=> !ovr_flag);

  // R10
  brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag);

  // R9
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && fifo_count == FIFO_DEPTH[$clog2(FIFO_DEPTH+1)-1:0]) |=> ovr_flag);
endmodule

// File: tb/rx_serial_brk_bench.sv
module rx_serial_brk_bench;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd_in = 1'b1;
  logic       os_tick = 1'b0;
  logic       cfg_len7 = 1'b0, cfg_stop2 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       rd_en = 1'b0, ovr_clr = 1'b0, brk_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, fifo_empty, ovr_flag, brk_flag;
  logic [4:0] fifo_count;
  int         nchk = 0, nerr = 0;

  rx_serial_brk u_rx_serial_brk (
    .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .os_tick(os_tick),
    .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .rd_en(rd_en), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .fifo_empty(fifo_empty),
    .fifo_count(fifo_count), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
    .brk_flag(brk_flag), .brk_clr(brk_clr)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      os_tick = ~os_tick;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    rxd_in = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_data(input logic [7:0] d);
    return cfg_len7 ? (d & 8'h7f) : d;
  endfunction

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [7:0] m;
    m = mask_data(d);
    line_bit(1'b0);
    for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) line_bit(m[i]);
    if (cfg_par_en) line_bit((^m) ^ cfg_par_odd ^ bad_par);
    line_bit(~bad_stop);
    if (cfg_stop2) line_bit(1'b1);
    line_bit(1'b1);
  endtask

  task automatic pop_check(input string req, input logic [7:0] ed, input logic ep, input logic ef);
    chk(req, "not empty", fifo_empty, 0);
    chk(req, "data", rd_data, ed);
    chk(req, "perr", rd_perr, ep);
    chk(req, "ferr", rd_ferr, ef);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {cfg_par_odd, cfg_par_en, cfg_stop2, cfg_len7} = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hff, 8'h55, 8'ha5, 8'h3c, 8'h81};
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", "empty", fifo_empty, 1);
    chk("R1", "count", fifo_count, 0);
    chk("R1", "ovr", ovr_flag, 0);
    chk("R1", "brk", brk_flag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 format sweep over all configuration codes
    for (int c = 0; c < 16; c++) begin
      set_cfg(4'(c));
      repeat (4) @(negedge clk);
      for (int k = 0; k < 6; k++) send(pats[k], 1'b0, 1'b0);
      send(8'h6b, 1'b1, 1'b0);
      chk("R8", "level after burst", fifo_count, 7);
      for (int k = 0; k < 6; k++)
        pop_check(cfg_len7 ? "R3" : "R2", mask_data(pats[k]), 1'b0, 1'b0);
      pop_check("R4", mask_data(8'h6b), cfg_par_en, 1'b0);
      chk("R8", "drained", fifo_empty, 1);
    end

    // R5 framing error, one and two stop bits; no break on short low
    for (int s = 0; s < 2; s++) begin
      set_cfg({3'b000, 1'b0} | (s == 1 ? 4'b0010 : 4'b0000));
      send(8'h5a, 1'b0, 1'b1);
      pop_check("R5", 8'h5a, 1'b0, 1'b1);
      chk("R6", "no break after short low", brk_flag, 0);
    end

    // R11 false start
    set_cfg(4'b0000);
    rxd_in = 1'b0;
    repeat (6) @(negedge clk);
    rxd_in = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    chk("R11", "glitch stores nothing", fifo_count, 0);

    // R6 R7 break
    rxd_in = 1'b0;
    repeat (30 * BITCLK) @(negedge clk);
    chk("R6", "break flag", brk_flag, 1);
    chk("R7", "one entry during break", fifo_count, 1);
    rxd_in = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    send(8'hc3, 1'b0, 1'b0);
    chk("R7", "level after resume", fifo_count, 2);
    pop_check("R7", 8'h00, 1'b0, 1'b1);
    pop_check("R7", 8'hc3, 1'b0, 1'b0);
    chk("R10", "break sticky", brk_flag, 1);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    chk("R10", "break cleared", brk_flag, 0);

    // R9 overrun
    for (int i = 0; i < 17; i++) send(8'(8'h10 + i), 1'b0, 1'b0);
    chk("R9", "count full", fifo_count, 16);
    chk("R9", "ovr set", ovr_flag, 1);
    for (int i = 0; i < 16; i++) pop_check("R9", 8'(8'h10 + i), 1'b0, 1'b0);
    chk("R8", "empty after drain", fifo_empty, 1);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R8", "pop on empty ignored", fifo_count, 0);
    chk("R10", "ovr sticky", ovr_flag, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R10", "ovr cleared", ovr_flag, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule